// File: doc/BRIEF.md
# Dimension-Order Offset Router Node

This block makes the routing decision for one switch of a two-dimensional mesh or torus. A packet header carries no absolute address. Instead it holds one signed hop count for each axis, giving the remaining distance to the destination. When a header is accepted, the node checks the header's CRC. It then chooses one of five exits: local delivery, +X, -X, +Y or -Y. It steps the offset of the axis being travelled one unit toward zero, recomputes the CRC over the modified header, and presents the result on a shared output bus. The valid line of the chosen exit pulses for one cycle.

Routing is dimension ordered. The X distance is consumed completely before any Y movement takes place, so every packet follows the same deterministic L-shaped path. A header that arrives with a CRC mismatch is discarded, and a one-cycle error pulse is raised in its place. The decision and the rewritten header are registered, so the fabric sees them exactly one cycle after the input handshake.

The header is 40 bits wide. Bits [39:32] hold the X offset and bits [31:24] hold the Y offset, both as 8-bit two's complement. Bits [23:8] are opaque carry-along bits. Bits [7:0] hold the CRC-8, which uses polynomial x^8+x^2+x+1 (0x07) with a zero initial value. The CRC is computed most significant bit first over header bits [39:8].

Top module: `route_node`

## Requirements
- R1: While reset is high, in_ready is low. On the first cycle after reset, all five exit valids and crc_err are low.
- R2: If the X offset is positive, the +X exit is chosen and the output X offset equals the input X offset minus one.
- R3: If the X offset is negative, the -X exit is chosen and the output X offset equals the input X offset plus one.
- R4: If the X offset is zero and the Y offset is positive, the +Y exit is chosen and the output Y offset equals the input Y offset minus one.
- R5: If the X offset is zero and the Y offset is negative, the -Y exit is chosen and the output Y offset equals the input Y offset plus one.
- R6: If both offsets are zero, the local exit is chosen and both output offsets stay zero.
- R7: When the X offset is nonzero, the Y offset passes through unchanged, whatever its value.
- R8: On every forwarded header, bits [23:8] are unchanged, and bits [7:0] hold the CRC-8 (poly 0x07, init 0, MSB first) of the output bits [39:8].
- R9: A header whose bits [7:0] differ from the CRC of its bits [39:8] raises no exit valid. It raises crc_err for exactly one cycle.
- R10: Outputs appear on the cycle after the accepting clock edge and last one cycle. At most one of the five valids and crc_err is high at any time, and a cycle with no handshake produces no output in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming header is valid |
| in_ready | output | 1 | Node can accept a header |
| in_hdr | input | 40 | Incoming header |
| out_local_v | output | 1 | Deliver to local endpoint |
| out_xp_v | output | 1 | Forward toward +X |
| out_xm_v | output | 1 | Forward toward -X |
| out_yp_v | output | 1 | Forward toward +Y |
| out_ym_v | output | 1 | Forward toward -Y |
| out_hdr | output | 40 | Rewritten header with new CRC |
| crc_err | output | 1 | One-cycle pulse when a corrupted header is dropped |

## Verification
The bench targets the extreme offsets +127 and -128. A design that saturated, wrapped or tested the wrong sign bit would send these the wrong way or emit a bad offset. It feeds headers with both offsets nonzero to catch a node that steps Y early or alters Y while X is still moving. It also feeds headers whose last remaining hop is ±1, to catch a node that overshoots or fails to reach zero. A header with one flipped CRC bit must be dropped with an error pulse: a design that forwarded it, or held the pulse longer than a cycle, is caught. Back-to-back headers and an idle cycle catch stale or sticky valids.

// File: rtl/rt_pkg.sv
package rt_pkg;
    localparam int OFS_W   = 8;
    localparam int REST_W  = 16;
    localparam int CRC_W   = 8;
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;
    localparam int BODY_W  = 2 * OFS_W + REST_W;
    localparam int HDR_W   = BODY_W + CRC_W;
    localparam int NPORT   = 5;

    typedef struct packed {
        logic [OFS_W-1:0]  dx;
        logic [OFS_W-1:0]  dy;
        logic [REST_W-1:0] rest;
        logic [CRC_W-1:0]  crc;
    } hdr_t;

    typedef enum logic [2:0] {
        EXIT_LOCAL = 3'd0,
        EXIT_XP    = 3'd1,
        EXIT_XM    = 3'd2,
        EXIT_YP    = 3'd3,
        EXIT_YM    = 3'd4
    } exit_e;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction
endpackage

// File: rtl/rt_crc.sv
module rt_crc
    import rt_pkg::*;
#(
    parameter int DW = BODY_W
) (
    input  logic [DW-1:0]    data,
    output logic [CRC_W-1:0] crc
);
    always_comb begin
        crc = '0;
        for (int i = DW - 1; i >= 0; i--) begin
            crc = crc_step(crc, data[i]);
        end
    end
endmodule

// File: rtl/rt_route_dec.sv
module rt_route_dec
    import rt_pkg::*;
(
    input  hdr_t  hin,
    output exit_e sel,
    output hdr_t  hout
);
    logic signed [OFS_W-1:0] sx, sy;
    logic x_zero, y_zero;

    assign sx = $signed(hin.dx);
    assign sy = $signed(hin.dy);
    assign x_zero = (hin.dx == '0);
    assign y_zero = (hin.dy == '0);

    always_comb begin
        hout     = hin;
        hout.crc = '0;
        sel      = EXIT_LOCAL;
        if (!x_zero) begin
            if (sx > 0) begin
                sel     = EXIT_XP;
                hout.dx = hin.dx - 1'b1;
            end else begin
                sel     = EXIT_XM;
                hout.dx = hin.dx + 1'b1;
            end
        end else if (!y_zero) begin
            if (sy > 0) begin
                sel     = EXIT_YP;
                hout.dy = hin.dy - 1'b1;
            end else begin
                sel     = EXIT_YM;
                hout.dy = hin.dy + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rt_out_reg.sv
module rt_out_reg
    import rt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             crc_ok,
    input  exit_e            sel,
    input  hdr_t             hnext,
    output logic [NPORT-1:0] vld,
    output logic             err,
    output hdr_t             hreg
);
    logic [NPORT-1:0] sel_oh;

    for (genvar g = 0; g < NPORT; g++) begin : g_dec
        assign sel_oh[g] = (sel == exit_e'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld  <= '0;
            err  <= 1'b0;
            hreg <= '0;
        end else begin
            vld <= '0;
            err <= 1'b0;
            if (take) begin
                if (crc_ok) begin
                    vld  <= sel_oh;
                    hreg <= hnext;
                end else begin
                    err <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/route_node.sv
module route_node
    import rt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [HDR_W-1:0] in_hdr,
    output logic             out_local_v,
    output logic             out_xp_v,
    output logic             out_xm_v,
    output logic             out_yp_v,
    output logic             out_ym_v,
    output logic [HDR_W-1:0] out_hdr,
    output logic             crc_err
);
    hdr_t             hin, hmid, hnext, hreg;
    logic [CRC_W-1:0] crc_chk, crc_new;
    exit_e            sel;
    logic [NPORT-1:0] vld;
    logic             take;

    assign hin      = hdr_t'(in_hdr);
    assign in_ready = !rst;
    assign take     = in_valid && in_ready;

    rt_crc #(.DW(BODY_W)) u_crc_in (
        .data (in_hdr[HDR_W-1:CRC_W]),
        .crc  (crc_chk)
    );

    rt_route_dec u_dec (
        .hin  (hin),
        .sel  (sel),
        .hout (hmid)
    );

    rt_crc #(.DW(BODY_W)) u_crc_out (
        .data ({hmid.dx, hmid.dy, hmid.rest}),
        .crc  (crc_new)
    );

    always_comb begin
        hnext     = hmid;
        hnext.crc = crc_new;
    end

    rt_out_reg u_reg (
        .clk    (clk),
        .rst    (rst),
        .take   (take),
        .crc_ok (crc_chk == hin.crc),
        .sel    (sel),
        .hnext  (hnext),
        .vld    (vld),
        .err    (crc_err),
        .hreg   (hreg)
    );

    assign out_local_v = vld[EXIT_LOCAL];
    assign out_xp_v    = vld[EXIT_XP];
    assign out_xm_v    = vld[EXIT_XM];
    assign out_yp_v    = vld[EXIT_YP];
    assign out_ym_v    = vld[EXIT_YM];
    assign out_hdr     = hreg;
endmodule

// File: rtl/rt_chk.sv
module rt_chk
    import rt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic [HDR_W-1:0] in_hdr,
    input logic             out_local_v,
    input logic             out_xp_v,
    input logic             out_xm_v,
    input logic             out_yp_v,
    input logic             out_ym_v,
    input logic [HDR_W-1:0] out_hdr,
    input logic             crc_err
);
    hdr_t oh, ih;
    logic any_v;
    assign oh    = hdr_t'(out_hdr);
    assign ih    = hdr_t'(in_hdr);
    assign any_v = out_local_v | out_xp_v | out_xm_v | out_yp_v | out_ym_v;

    a_r1_ready_low: assert property (@(posedge clk) rst |-> !in_ready);

    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_local_v, out_xp_v, out_xm_v, out_yp_v, out_ym_v, crc_err}));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> !(any_v || crc_err));

    a_r2_xp_step: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && $signed(ih.dx) > 0 && !rst) |=>
            ((out_xp_v || crc_err) && (crc_err || oh.dx == $past(ih.dx) - 8'd1)));

    a_r3_xm_step: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && $signed(ih.dx) < 0) |=>
            ((out_xm_v && oh.dx == $past(ih.dx) + 8'd1) || crc_err));

    a_r7_y_waits: assert property (@(posedge clk) disable iff (rst)
        (out_yp_v || out_ym_v) |-> (oh.dx == '0));

    a_r6_local_zero: assert property (@(posedge clk) disable iff (rst)
        out_local_v |-> (oh.dx == '0 && oh.dy == '0));

    a_r9_err_pulse: assert property (@(posedge clk) disable iff (rst)
        crc_err |=> (!crc_err || $past(in_valid && in_ready)));
endmodule

bind route_node rt_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_hdr      (in_hdr),
    .out_local_v (out_local_v),
    .out_xp_v    (out_xp_v),
    .out_xm_v    (out_xm_v),
    .out_yp_v    (out_yp_v),
    .out_ym_v    (out_ym_v),
    .out_hdr     (out_hdr),
    .crc_err     (crc_err)
);

// File: tb/route_node_test.sv
module route_node_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [39:0] in_hdr = '0;
    logic        out_local_v, out_xp_v, out_xm_v, out_yp_v, out_ym_v, crc_err;
    logic [39:0] out_hdr;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    route_node uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_hdr(in_hdr),
        .out_local_v(out_local_v), .out_xp_v(out_xp_v), .out_xm_v(out_xm_v),
        .out_yp_v(out_yp_v), .out_ym_v(out_ym_v), .out_hdr(out_hdr), .crc_err(crc_err)
    );

    // exit codes: 0 local, 1 +X, 2 -X, 3 +Y, 4 -Y
    // entry: {dx, dy, exit code, expected dx, expected dy}
    localparam int NV = 12;
    localparam logic [NV-1:0][34:0] VEC = {
        {8'sd3,    8'sd5,    3'd1, 8'sd2,    8'sd5},    // R2 R7
        {-8'sd4,   8'sd2,    3'd2, -8'sd3,   8'sd2},    // R3 R7
        {8'sd0,    8'sd7,    3'd3, 8'sd0,    8'sd6},    // R4
        {8'sd0,    -8'sd1,   3'd4, 8'sd0,    8'sd0},    // R5
        {8'sd0,    8'sd0,    3'd0, 8'sd0,    8'sd0},    // R6
        {8'sd127,  -8'sd128, 3'd1, 8'sd126,  -8'sd128}, // R2 R7
        {-8'sd128, 8'sd0,    3'd2, -8'sd127, 8'sd0},    // R3
        {8'sd1,    8'sd0,    3'd1, 8'sd0,    8'sd0},    // R2
        {8'sd0,    -8'sd128, 3'd4, 8'sd0,    -8'sd127}, // R5
        {-8'sd1,   -8'sd1,   3'd2, 8'sd0,    -8'sd1},   // R3 R7
        {8'sd0,    8'sd1,    3'd3, 8'sd0,    8'sd0},    // R4
        {8'sd0,    8'sd127,  3'd3, 8'sd0,    8'sd126}   // R4
    };

    function automatic logic [7:0] ref_crc(input logic [31:0] body);
        logic [7:0] c = 8'h00;
        for (int i = 31; i >= 0; i--) begin
            logic top = c[7] ^ body[i];
            c = {c[6:0], 1'b0};
            if (top) c = c ^ 8'h07;
        end
        return c;
    endfunction

    function automatic logic [39:0] mk_hdr(input logic [7:0] dx, input logic [7:0] dy, input logic [15:0] rest);
        return {dx, dy, rest, ref_crc({dx, dy, rest})};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] vlds();
        return {out_ym_v, out_yp_v, out_xm_v, out_xp_v, out_local_v};
    endfunction

    // drive at negedge, accepted at next posedge, sampled at the following negedge
    task automatic send(input logic [39:0] h);
        in_hdr   = h;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [39:0] h, h2;
        @(negedge clk);
        check("R1 ready in reset", {63'd0, in_ready}, 64'd0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valids after reset", {59'd0, vlds()}, 64'd0);
        check("R1 err after reset", {63'd0, crc_err}, 64'd0);
        check("R1 ready after reset", {63'd0, in_ready}, 64'd1);

        for (int i = 0; i < NV; i++) begin
            logic [34:0] e = VEC[NV-1-i];
            logic [15:0] rest = 16'hA5C3 ^ 16'(i * 16'h1111);
            send(mk_hdr(e[34:27], e[26:19], rest));
            check("R2-R6 exit select", {59'd0, vlds()}, 64'd1 << e[18:16]);
            check("R2-R7 offsets", {48'd0, out_hdr[39:24]}, {48'd0, e[15:0]});
            check("R8 rest and crc", {24'd0, out_hdr},
                  {24'd0, mk_hdr(e[15:8], e[7:0], rest)});
            check("R9 no err on good", {63'd0, crc_err}, 64'd0);
            @(negedge clk);
            check("R10 one-cycle pulse", {59'd0, vlds()}, 64'd0);
        end

        // R9: corrupted CRC
        h = mk_hdr(8'd2, 8'd3, 16'h1234) ^ 40'h1;
        send(h);
        check("R9 err pulse", {63'd0, crc_err}, 64'd1);
        check("R9 no exit valid", {59'd0, vlds()}, 64'd0);
        @(negedge clk);
        check("R9 err one cycle", {63'd0, crc_err}, 64'd0);

        // R10: back-to-back headers
        h  = mk_hdr(8'd0, -8'sd3, 16'hBEEF);
        h2 = mk_hdr(8'd5, 8'd0, 16'hCAFE);
        in_hdr = h; in_valid = 1'b1;
        @(negedge clk);
        in_hdr = h2;
        check("R10 back-to-back first", {59'd0, vlds()}, 64'd16);
        check("R5 back-to-back dy", {56'd0, out_hdr[31:24]}, 64'hFE);
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 back-to-back second", {59'd0, vlds()}, 64'd2);
        check("R8 back-to-back crc", {24'd0, out_hdr}, {24'd0, mk_hdr(8'd4, 8'd0, 16'hCAFE)});
        @(negedge clk);
        check("R10 idle quiet", {58'd0, crc_err, vlds()}, 64'd0);

        // R1: reset mid-stream clears outputs
        in_hdr = mk_hdr(8'd1, 8'd1, 16'h0); in_valid = 1'b1; rst = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 reset blocks accept", {58'd0, crc_err, vlds()}, 64'd0);
        check("R1 ready low mid reset", {63'd0, in_ready}, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule